// File: doc/BRIEF.md
# Two-Stage Decoded Bit-Slice Static Memory

This block is a synchronous static memory of 32768 words, each 8 bits wide. It is not one flat word array with a single 15-to-32K decoder. Its storage is eight bit-slice arrays, one for each data bit. Each slice holds 512 rows of 64 bits.

Every access is decoded in two stages:

- **Row decode.** The upper address bits go through a shared one-hot row decoder. It picks the same 64-bit row in all eight slices.
- **Column select.** The lower address bits pick one bit out of each selected row. This gives one data bit per slice.

Read data is steered by multiplexers only; there are no tri-state drivers.

A client drives an address, write data, a write strobe and a read (output) enable on each clock.

- **Writes** land on the rising edge and touch only the addressed bit of each slice.
- **Reads** are registered and appear one cycle after the request.
- **Data output** is forced to zero whenever the read enable was low in the request cycle.

Top module: `sram2d_top`

## Requirements
- R1: Every one of the 32768 addresses (15-bit address) holds its own 8-bit value; writing one address never changes the value read back from another address that was written earlier.
- R2: Address bits 14:6 form the row index and bits 5:0 form the column index. While a write or read is requested, exactly one row line of the 512-line decoder is active: the one numbered by bits 14:6. While neither is requested, no row line is active.
- R3: A cycle with `wr_en`=1 stores `wr_data` at `addr`, and a later read of that address returns it; repeated reads of an unchanged address with no write in between return the same value.
- R4: A write changes only the addressed bit in each slice. Addresses in the same row but another column, or in the same column but another row, keep their values.
- R5: A read requested in cycle N (`rd_en`=1) shows its data on `rd_data` after the rising edge that ends cycle N; `rd_data` does not change before that edge.
- R6: If `rd_en` is 0 in a cycle, `rd_data` is 0 after that cycle's rising edge, whether or not a write happens.
- R7: If `wr_en` and `rd_en` are both 1 in the same cycle, the write is performed and `rd_data` shows the value stored before that write.
- R8: While `rst` is 1 at a rising edge, `rd_data` becomes 0 after that edge. Memory contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the output register |
| addr | input | 15 | Word address: row in 14:6, column in 5:0 |
| wr_data | input | 8 | Data to store |
| wr_en | input | 1 | Store `wr_data` at `addr` on this edge |
| rd_en | input | 1 | Request a read of `addr`; its data appears one cycle later |
| rd_data | output | 8 | Registered read data, zero when no read was requested |

## Verification
The table walk writes, then reads back, a set of addresses chosen to stress the decode:

- the lowest and highest words;
- words that share a row but differ in column (0x0000, 0x0001, 0x003F);
- words that share a column but differ in row (0x0000, 0x0040, 0x7FC0);
- scattered words with alternating address bits.

A swapped or truncated row/column split makes two of these alias, and one readback then fails. The data patterns include all-ones, all-zeros and alternating bits, so a slice wired to the wrong data bit shows up.

Directed cases then cover four things:

- overwriting one word and re-reading its row and column neighbours;
- a combined write-and-read, which must return the old value;
- output gating with the read enable low;
- the exact edge at which read data appears, and reset.

// File: rtl/sram2d_pkg.sv
package sram2d_pkg;

    localparam int ADDR_W_DEF = 15;
    localparam int DATA_W_DEF = 8;
    localparam int COL_W_DEF  = 6;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_BOTH  = 2'b11
    } access_e;

    function automatic access_e classify(input logic wr, input logic rd);
        return access_e'({wr, rd});
    endfunction

    function automatic logic is_active(input access_e kind);
        return kind != ACC_IDLE;
    endfunction

    function automatic logic is_write(input access_e kind);
        return (kind == ACC_WRITE) || (kind == ACC_BOTH);
    endfunction

    function automatic logic is_read(input access_e kind);
        return (kind == ACC_READ) || (kind == ACC_BOTH);
    endfunction

endpackage

// File: rtl/sram2d_row_decode.sv
module sram2d_row_decode #(
    parameter int ROW_W = 9,
    localparam int ROWS = 1 << ROW_W
) (
    input  logic             en,
    input  logic [ROW_W-1:0] row,
    output logic [ROWS-1:0]  row_sel
);

    for (genvar r = 0; r < ROWS; r++) begin : g_line
        assign row_sel[r] = en && (row == ROW_W'(r));
    end

endmodule

// File: rtl/sram2d_slice.sv
module sram2d_slice #(
    parameter int ROW_W = 9,
    parameter int COL_W = 6,
    localparam int ROWS = 1 << ROW_W,
    localparam int COLS = 1 << COL_W
) (
    input  logic             clk,
    input  logic [ROWS-1:0]  row_sel,
    input  logic [COL_W-1:0] col,
    input  logic             wr,
    input  logic             wbit,
    output logic [COLS-1:0]  row_word
);

    logic [COLS-1:0] cells [ROWS];

    always_ff @(posedge clk) begin
        for (int r = 0; r < ROWS; r++) begin
            if (wr && row_sel[r]) begin
                cells[r][col] <= wbit;
            end
        end
    end

    always_comb begin
        row_word = '0;
        for (int r = 0; r < ROWS; r++) begin
            row_word = row_word | (cells[r] & {COLS{row_sel[r]}});
        end
    end

endmodule

// File: rtl/sram2d_col_mux.sv
module sram2d_col_mux #(
    parameter int COL_W = 6,
    localparam int COLS = 1 << COL_W
) (
    input  logic [COLS-1:0]  word,
    input  logic [COL_W-1:0] col,
    output logic             bit_out
);

    logic [COLS-1:0] stage [COL_W+1];

    assign stage[0] = word;

    for (genvar l = 0; l < COL_W; l++) begin : g_level
        localparam int N = COLS >> (l + 1);
        for (genvar i = 0; i < N; i++) begin : g_pair
            assign stage[l+1][i] = col[l] ? stage[l][2*i+1] : stage[l][2*i];
        end
        if (N < COLS) begin : g_pad
            assign stage[l+1][COLS-1:N] = '0;
        end
    end

    assign bit_out = stage[COL_W][0];

endmodule

// File: rtl/sram2d_top.sv
module sram2d_top
    import sram2d_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int COL_W  = COL_W_DEF,
    localparam int ROW_W = ADDR_W - COL_W,
    localparam int ROWS  = 1 << ROW_W,
    localparam int COLS  = 1 << COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);

    access_e          kind;
    logic [ROW_W-1:0] row_idx;
    logic [COL_W-1:0] col_idx;
    logic [ROWS-1:0]  row_sel;
    logic [DATA_W-1:0] slice_bits;

    assign kind    = classify(wr_en, rd_en);
    assign row_idx = addr[ADDR_W-1:COL_W];
    assign col_idx = addr[COL_W-1:0];

    sram2d_row_decode #(.ROW_W(ROW_W)) u_rowdec (
        .en      (is_active(kind)),
        .row     (row_idx),
        .row_sel (row_sel)
    );

    for (genvar s = 0; s < DATA_W; s++) begin : g_slice
        logic [COLS-1:0] word;

        sram2d_slice #(.ROW_W(ROW_W), .COL_W(COL_W)) u_slice (
            .clk      (clk),
            .row_sel  (row_sel),
            .col      (col_idx),
            .wr       (is_write(kind)),
            .wbit     (wr_data[s]),
            .row_word (word)
        );

        sram2d_col_mux #(.COL_W(COL_W)) u_cmux (
            .word    (word),
            .col     (col_idx),
            .bit_out (slice_bits[s])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (is_read(kind)) begin
            rd_data <= slice_bits;
        end else begin
            rd_data <= '0;
        end
    end

endmodule

// File: rtl/sram2d_checker.sv
module sram2d_checker #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int ROW_W  = 9,
    localparam int ROWS  = 1 << ROW_W
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic [ROWS-1:0]   row_sel
);

    p_row_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en || rd_en) |-> ($countones(row_sel) == 1 && row_sel[addr[ADDR_W-1:ADDR_W-ROW_W]]));

    p_row_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !(wr_en || rd_en) |-> ($countones(row_sel) == 0));

    p_oe_low_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rd_data == '0));

    p_reset_zero_r8: assert property (@(posedge clk)
        rst |=> (rd_data == '0));

    p_reread_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && $past(rd_en && !wr_en && !rst) && $stable(addr)) |=> $stable(rd_data));

endmodule

bind sram2d_top sram2d_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ROW_W  (ROW_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .row_sel (row_sel)
);

// File: tb/sram2d_top_bench.sv
module sram2d_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sram2d_top u_sram2d_top (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_data (wr_data),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .rd_data (rd_data)
    );

    localparam int NV = 12;
    localparam logic [22:0] VEC [NV] = '{
        {15'h0000, 8'hA5}, {15'h0001, 8'h5A}, {15'h003F, 8'h3C},
        {15'h0040, 8'hC3}, {15'h7FFF, 8'h81}, {15'h7FC0, 8'h7E},
        {15'h1234, 8'h00}, {15'h1235, 8'hFF}, {15'h2A95, 8'h96},
        {15'h5555, 8'h69}, {15'h4000, 8'h0F}, {15'h03C0, 8'hF0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rd_data=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic r, input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wr_data = d;
        @(posedge clk);
        #5;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(0, 0, '0, '0);
        cyc(0, 0, '0, '0);
        check("R8 reset state", rd_data, 8'h00);
        @(negedge clk); rst = 1'b0;

        // R1 R2 R3: write the table, then read it back
        for (int i = 0; i < NV; i++) begin
            cyc(1, 0, VEC[i][22:8], VEC[i][7:0]);
            check("R6 write without read", rd_data, 8'h00);
        end
        for (int i = 0; i < NV; i++) begin
            cyc(0, 1, VEC[i][22:8], 8'h00);
            check("R1 R2 R3 table readback", rd_data, VEC[i][7:0]);
        end

        // R3: repeated read returns same value
        cyc(0, 1, 15'h2A95, 8'h00);
        cyc(0, 1, 15'h2A95, 8'h00);
        check("R3 repeated read", rd_data, 8'h96);

        // R4: overwrite 0x0000; row and column neighbours untouched
        cyc(1, 0, 15'h0000, 8'h33);
        cyc(0, 1, 15'h0000, 8'h00);
        check("R4 overwritten word", rd_data, 8'h33);
        cyc(0, 1, 15'h0001, 8'h00);
        check("R4 same row neighbour", rd_data, 8'h5A);
        cyc(0, 1, 15'h003F, 8'h00);
        check("R4 same row far column", rd_data, 8'h3C);
        cyc(0, 1, 15'h0040, 8'h00);
        check("R4 same column next row", rd_data, 8'hC3);
        cyc(0, 1, 15'h7FC0, 8'h00);
        check("R4 same column last row", rd_data, 8'h7E);

        // R7: write and read together return old value
        cyc(1, 1, 15'h1234, 8'h5A);
        check("R7 combined access old data", rd_data, 8'h00);
        cyc(0, 1, 15'h1234, 8'h00);
        check("R7 combined access stored", rd_data, 8'h5A);

        // R6: read enable low gates output
        cyc(0, 1, 15'h7FFF, 8'h00);
        cyc(0, 0, 15'h7FFF, 8'h00);
        check("R6 output gated", rd_data, 8'h00);
        cyc(1, 0, 15'h5555, 8'hAA);
        check("R6 write only gated", rd_data, 8'h00);
        cyc(0, 1, 15'h5555, 8'h00);
        check("R3 write only stored", rd_data, 8'hAA);

        // R5: data appears only after the edge ending the request cycle
        cyc(0, 0, '0, '0);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b1; addr = 15'h7FFF;
        #2;
        check("R5 no early data", rd_data, 8'h00);
        @(posedge clk);
        #5;
        check("R5 one cycle latency", rd_data, 8'h81);

        // R8: reset clears output, not contents
        @(negedge clk); rst = 1'b1;
        @(posedge clk);
        #5;
        check("R8 reset clears output", rd_data, 8'h00);
        @(negedge clk); rst = 1'b0;
        cyc(0, 1, 15'h7FFF, 8'h00);
        check("R8 contents kept", rd_data, 8'h81);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule